// File: doc/BRIEF.md
# Vectored Interrupt Message Controller

This block gathers a bank of external interrupt lines (64 by default) and turns them into vectored interrupt messages. Software sets each line to edge or level detection and to either polarity, and can mask it or stop it from producing messages. Edge detection latches a sticky pending bit that software discards with a write-one-to-clear access. In level mode the pending state tracks the input directly.

Whenever at least one line is pending, unmasked and allowed to send messages, the lowest-numbered such line wins. Its programmable vector byte and route byte, together with its index, go out on a valid/ready port. Delivering a message does not clear the pending state. Software must clear edge lines itself, or a level line must drop its input.

The controller sits on a simple 32-bit register bus. Writes take effect on a clock edge. Reads are combinational from the address and have no side effects. Per-line bit registers span consecutive words, 32 lines to a word. Each line also has a byte-wide route entry and a byte-wide vector entry.

Top module: `vecirq_ctrl`

## Requirements
- R1: After reset, every line is masked and every message-enable bit is 1. The edge-mode, polarity, both spare words and all table bytes read 0, and msg_valid is 0.
- R2: These word registers read back the value last written: mask (0x20 + 4w), message enable (0x40 + 4w), edge mode (0x60 + 4w), polarity (0x3E0 + 4w), and the two spare storage words (0xC0 + 4w, 0xE0 + 4w). Line L is bit L%32 of word w = L/32. The spare words affect nothing.
- R3: The route byte of line L is at 0x100 + L and its vector byte is at 0x200 + L. Only write data bits 7:0 are stored, and reads return the byte in bits 7:0 with bits 31:8 at zero.
- R4: Reads of unmapped addresses return 0, and writes to them change no register. The clear address 0x80 + 4w reads as 0.
- R5: With edge bit 0 (level mode), a line is pending while its synchronised input XOR its polarity bit is 1. Polarity 0 means active-high and polarity 1 means active-low.
- R6: With edge bit 1, a rising edge (polarity 0) or a falling edge (polarity 1) of the synchronised input sets a pending bit. That bit stays set after the input returns. An edge of the opposite direction sets nothing.
- R7: Writing 1 to bit L%32 of the clear word 0x80 + 4*(L/32) discards line L's edge-pending bit. Zero bits in that write leave the other lines' pending bits unchanged.
- R8: A pending line produces a message only while its mask bit is 0 and its message-enable bit is 1.
- R9: Among deliverable lines, the lowest-numbered line wins. The message carries msg_line = L, msg_vector = vector byte of L and msg_route = route byte of L.
- R10: While msg_valid is 1 and msg_ready is 0, msg_line, msg_vector and msg_route are held. On acceptance, the current winner is loaded. A pending edge line that is still pending is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINES | Asynchronous interrupt inputs |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | VW | Vector byte of the winning line |
| msg_route | output | VW | Route byte of the winning line |
| msg_line | output | $clog2(NLINES) | Index of the winning line |

## Verification
The bench aims at the following corner cases and the failure each one exposes:

- **Bit-to-word mapping.** Lines on both sides of the word boundary (31/32 and 63) and line 0 expose a design that maps lines to words or bits incorrectly. Such a design would deliver the wrong line or read back shifted bits.
- **Polarity in both modes.** Falling edges on an active-low edge line, and a falling transition on an active-high edge line, are driven on purpose. Inverted polarity handling would latch the wrong direction or none.
- **Clear writes.** A clear word holding 1s everywhere except the pending line's bit checks that zero bits have no effect. A clear that acts on the whole word would lose that pending state.
- **Payload hold.** Masking the line currently being offered, while the consumer stalls, checks that the payload is held. A design that re-arbitrates on every cycle would change msg_line under a stalled consumer.
- **Address decoding.** Unmapped addresses next to real words check the decoder. A partial decoder would alias writes onto the mask.

// File: rtl/vecirq_ctrl.sv
module vecirq_ctrl #(
  parameter int NLINES = 64,
  parameter int AW     = 12,
  parameter int VW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLINES-1:0]         irq_in,
  input  logic                      bus_wen,
  input  logic [AW-1:0]             bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [VW-1:0]             msg_vector,
  output logic [VW-1:0]             msg_route,
  output logic [$clog2(NLINES)-1:0] msg_line
);
  localparam int NWORDS = NLINES / 32;
  localparam int IW     = $clog2(NLINES);
  localparam logic [AW-1:0] OFS_MASK  = AW'('h020);
  localparam logic [AW-1:0] OFS_MEN   = AW'('h040);
  localparam logic [AW-1:0] OFS_EDGE  = AW'('h060);
  localparam logic [AW-1:0] OFS_CLR   = AW'('h080);
  localparam logic [AW-1:0] OFS_SPA   = AW'('h0C0);
  localparam logic [AW-1:0] OFS_SPB   = AW'('h0E0);
  localparam logic [AW-1:0] OFS_POL   = AW'('h3E0);

  function automatic logic at_word(input logic [AW-1:0] a, input logic [AW-1:0] base, input int w);
    return a == base + AW'(4 * w);
  endfunction

  logic [NLINES-1:0] mask_r, men_r, edge_r, pol_r, epend;
  logic [NLINES-1:0] spa_r, spb_r;
  logic [NLINES-1:0] sync1, sync2, sync3;
  logic [NLINES-1:0] wclr, edge_hit, lvl, pend, deliv;
  logic [VW-1:0]     route_t [NLINES];
  logic [VW-1:0]     vec_t   [NLINES];
  logic              any;
  logic [IW-1:0]     win;
  logic              tbl_ok, rt_sel, vc_sel;
  logic [IW-1:0]     tbl_idx;

  assign tbl_ok  = {1'b0, bus_addr[7:0]} < 9'(NLINES);
  assign rt_sel  = tbl_ok && bus_addr[AW-1:8] == (AW-8)'(1);
  assign vc_sel  = tbl_ok && bus_addr[AW-1:8] == (AW-8)'(2);
  assign tbl_idx = bus_addr[IW-1:0];

  assign edge_hit = ((sync2 & ~sync3) & ~pol_r) | ((~sync2 & sync3) & pol_r);
  assign lvl      = sync2 ^ pol_r;
  assign pend     = (edge_r & epend) | (~edge_r & lvl);
  assign deliv    = pend & ~mask_r & men_r;

  always_comb begin
    wclr = '0;
    for (int w = 0; w < NWORDS; w++)
      if (bus_wen && at_word(bus_addr, OFS_CLR, w)) wclr[w*32 +: 32] = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; sync3 <= '0;
    end else begin
      sync1 <= irq_in; sync2 <= sync1; sync3 <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r <= '1; men_r <= '1; edge_r <= '0; pol_r <= '0;
      spa_r  <= '0; spb_r <= '0;
    end else if (bus_wen) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (at_word(bus_addr, OFS_MASK, w)) mask_r[w*32 +: 32] <= bus_wdata;
        if (at_word(bus_addr, OFS_MEN,  w)) men_r[w*32 +: 32]  <= bus_wdata;
        if (at_word(bus_addr, OFS_EDGE, w)) edge_r[w*32 +: 32] <= bus_wdata;
        if (at_word(bus_addr, OFS_POL,  w)) pol_r[w*32 +: 32]  <= bus_wdata;
        if (at_word(bus_addr, OFS_SPA,  w)) spa_r[w*32 +: 32]  <= bus_wdata;
        if (at_word(bus_addr, OFS_SPB,  w)) spb_r[w*32 +: 32]  <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        route_t[i] <= '0;
        vec_t[i]   <= '0;
      end
    end else if (bus_wen) begin
      if (rt_sel) route_t[tbl_idx] <= bus_wdata[VW-1:0];
      if (vc_sel) vec_t[tbl_idx]   <= bus_wdata[VW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) epend <= '0;
    else        epend <= (epend & ~wclr) | (edge_hit & edge_r);
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (at_word(bus_addr, OFS_MASK, w)) bus_rdata = mask_r[w*32 +: 32];
      if (at_word(bus_addr, OFS_MEN,  w)) bus_rdata = men_r[w*32 +: 32];
      if (at_word(bus_addr, OFS_EDGE, w)) bus_rdata = edge_r[w*32 +: 32];
      if (at_word(bus_addr, OFS_POL,  w)) bus_rdata = pol_r[w*32 +: 32];
      if (at_word(bus_addr, OFS_SPA,  w)) bus_rdata = spa_r[w*32 +: 32];
      if (at_word(bus_addr, OFS_SPB,  w)) bus_rdata = spb_r[w*32 +: 32];
    end
    if (rt_sel) bus_rdata[VW-1:0] = route_t[tbl_idx];
    if (vc_sel) bus_rdata[VW-1:0] = vec_t[tbl_idx];
  end

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (deliv[i]) begin
        any = 1'b1;
        win = IW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0; msg_line <= '0; msg_vector <= '0; msg_route <= '0;
    end else if (!msg_valid || msg_ready) begin
      msg_valid  <= any;
      msg_line   <= win;
      msg_vector <= vec_t[win];
      msg_route  <= route_t[win];
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_line) && $stable(msg_vector) && $stable(msg_route));

  p_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(|deliv));

  for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wclr[g] && !(edge_hit[g] && edge_r[g]) |=> !epend[g]);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      epend[g] && !wclr[g] |=> epend[g]);
  end
endmodule

// File: tb/tb_vecirq_ctrl.sv
`timescale 1ns/1ps
module tb_vecirq_ctrl;
  logic        clk = 0;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        bus_wen;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        msg_valid, msg_ready;
  logic [7:0]  msg_vector, msg_route;
  logic [5:0]  msg_line;

  int nchk = 0, nfail = 0;
  logic [63:0] m_mask, m_men, m_edge, m_pol, m_spa, m_spb;
  logic [7:0]  m_rt [64];
  logic [7:0]  m_vec [64];

  vecirq_ctrl dut (.clk, .rst_n, .irq_in, .bus_wen, .bus_addr, .bus_wdata, .bus_rdata,
                   .msg_valid, .msg_ready, .msg_vector, .msg_route, .msg_line);

  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wen = 0; bus_addr = 12'hFFF;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #2 d = bus_rdata;
  endtask

  task automatic wr64(input logic [11:0] a, input logic [63:0] v);
    wr(a, v[31:0]); wr(a + 12'd4, v[63:32]);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  function automatic int lowest(input logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check_msg(input string req, input int exp_line);
    if (exp_line < 0) check(req, "msg_valid idle", 64'(msg_valid), 64'd0);
    else begin
      check(req, "msg_valid", 64'(msg_valid), 64'd1);
      check(req, "msg_line", 64'(msg_line), 64'(exp_line));
      check(req, "msg_vector", 64'(msg_vector), 64'(m_vec[exp_line]));
      check(req, "msg_route", 64'(msg_route), 64'(m_rt[exp_line]));
    end
  endtask

  task automatic cfg_all();
    wr64(12'h060, m_edge); wr64(12'h3E0, m_pol); wr64(12'h040, m_men); wr64(12'h020, m_mask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed1));
    rst_n = 0; irq_in = '0; bus_wen = 0; bus_addr = 12'hFFF; bus_wdata = '0; msg_ready = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(12'h020, d); check("R1", "mask w0", 64'(d), 64'hFFFFFFFF);
    rd(12'h024, d); check("R1", "mask w1", 64'(d), 64'hFFFFFFFF);
    rd(12'h044, d); check("R1", "enable w1", 64'(d), 64'hFFFFFFFF);
    rd(12'h060, d); check("R1", "edge w0", 64'(d), 64'd0);
    rd(12'h3E4, d); check("R1", "pol w1", 64'(d), 64'd0);
    rd(12'h0C0, d); check("R1", "spare a", 64'(d), 64'd0);
    rd(12'h0E4, d); check("R1", "spare b", 64'(d), 64'd0);
    rd(12'h10A, d); check("R1", "route 10", 64'(d), 64'd0);
    rd(12'h23F, d); check("R1", "vector 63", 64'(d), 64'd0);
    check("R1", "msg_valid", 64'(msg_valid), 64'd0);

    // R2 random word writes with readback
    m_mask = '1; m_men = '1; m_edge = '0; m_pol = '0; m_spa = '0; m_spb = '0;
    for (int k = 0; k < 24; k++) begin
      int sel = int'($urandom % 6);
      int w   = int'($urandom % 2);
      logic [31:0] v = $urandom;
      logic [11:0] a;
      case (sel)
        0: begin a = 12'h020; m_mask[w*32 +: 32] = v; end
        1: begin a = 12'h040; m_men[w*32 +: 32]  = v; end
        2: begin a = 12'h060; m_edge[w*32 +: 32] = v; end
        3: begin a = 12'h3E0; m_pol[w*32 +: 32]  = v; end
        4: begin a = 12'h0C0; m_spa[w*32 +: 32]  = v; end
        default: begin a = 12'h0E0; m_spb[w*32 +: 32] = v; end
      endcase
      a = a + 12'(4 * w);
      wr(a, v);
      rd(a, d); check("R2", "word readback", 64'(d), 64'(v));
    end

    // R3 tables
    for (int i = 0; i < 64; i++) begin
      m_rt[i] = 8'($urandom); m_vec[i] = 8'($urandom);
      wr(12'h100 + 12'(i), {24'($urandom), m_rt[i]});
      wr(12'h200 + 12'(i), {24'($urandom), m_vec[i]});
    end
    for (int k = 0; k < 8; k++) begin
      int i = int'($urandom % 64);
      rd(12'h100 + 12'(i), d); check("R3", "route readback", 64'(d), 64'(m_rt[i]));
      rd(12'h200 + 12'(i), d); check("R3", "vector readback", 64'(d), 64'(m_vec[i]));
    end

    // R4 unmapped and clear reads
    rd(12'h028, d); check("R4", "unmapped 0x028", 64'(d), 64'd0);
    rd(12'h150, d); check("R4", "unmapped 0x150", 64'(d), 64'd0);
    rd(12'h300, d); check("R4", "unmapped 0x300", 64'(d), 64'd0);
    rd(12'h080, d); check("R4", "clear reads zero", 64'(d), 64'd0);
    wr(12'h028, 32'h0); wr(12'h150, 32'hA5);
    rd(12'h020, d); check("R4", "mask w0 untouched", 64'(d), 64'(m_mask[31:0]));
    rd(12'h024, d); check("R4", "mask w1 untouched", 64'(d), 64'(m_mask[63:32]));

    // R5 R8 R9 random level-mode delivery
    m_edge = '0;
    for (int k = 0; k < 30; k++) begin
      m_pol  = {$urandom, $urandom};
      m_mask = {$urandom, $urandom} | {$urandom, $urandom};
      m_men  = ~({$urandom, $urandom} & {$urandom, $urandom});
      cfg_all();
      irq_in = {$urandom, $urandom};
      settle(); take();
      check_msg("R5/R8/R9 level random", lowest((irq_in ^ m_pol) & ~m_mask & m_men));
    end

    // R8 directed
    m_pol = '0; m_mask = '1; m_men = '1; cfg_all();
    irq_in = 64'd1 << 12;
    m_men[12] = 0; m_mask[12] = 0; cfg_all(); settle(); take();
    check_msg("R8 enable off", -1);
    m_men[12] = 1; cfg_all(); settle(); take();
    check_msg("R8 enabled", 12);
    m_mask[12] = 1; cfg_all(); settle(); take();
    check_msg("R8 masked", -1);

    // R9 directed priority across word boundary
    m_mask = '0; cfg_all();
    irq_in = (64'd1 << 33) | (64'd1 << 63) | (64'd1 << 32); settle(); take();
    check_msg("R9 lowest of 32/33/63", 32);
    irq_in = (64'd1 << 63) | 64'd1; settle(); take();
    check_msg("R9 lowest of 0/63", 0);

    // R5 active-low
    m_pol = 64'd1 << 31; cfg_all();
    irq_in = '1; irq_in[31] = 0; m_mask = ~(64'd1 << 31); cfg_all(); settle(); take();
    check_msg("R5 active-low asserted", 31);
    irq_in[31] = 1; settle(); take();
    check_msg("R5 active-low released", -1);

    // R6 R7 edge mode
    irq_in = '0; m_mask = '1; m_pol = '0; m_edge = '0; cfg_all();
    irq_in[40] = 1; settle();
    m_edge[5] = 1; m_edge[40] = 1; m_pol[40] = 1; m_mask[5] = 0; m_mask[40] = 0;
    cfg_all(); settle(); take();
    check_msg("R6 no edge yet", -1);
    @(negedge clk); irq_in[5] = 1; @(negedge clk); irq_in[5] = 0;
    settle(); take();
    check_msg("R6 rising edge latched", 5);
    take();
    check_msg("R10 re-presented", 5);
    wr(12'h080, 32'hFFFFFFDF); settle(); take();
    check_msg("R7 zero bit keeps pending", 5);
    wr(12'h080, 32'h00000020); settle(); take();
    check_msg("R7 cleared", -1);
    @(negedge clk); irq_in[40] = 0; @(negedge clk); irq_in[40] = 1;
    settle(); take();
    check_msg("R6 falling edge active-low", 40);
    wr(12'h084, 32'h00000100); settle(); take();
    check_msg("R7 clear word1", -1);
    irq_in[5] = 1; settle();
    wr(12'h080, 32'h00000020); settle();
    irq_in[5] = 0; settle(); take();
    check_msg("R6 falling ignored on rising line", -1);

    // R10 hold under stall
    irq_in = '0; m_edge = '0; m_pol = '0; m_mask = '1; cfg_all();
    irq_in = (64'd1 << 3) | (64'd1 << 7);
    m_mask[3] = 0; m_mask[7] = 0; cfg_all(); settle(); take();
    check_msg("R10 first winner", 3);
    m_mask[3] = 1; wr64(12'h020, m_mask); settle();
    check_msg("R10 held while stalled", 3);
    take();
    check_msg("R10 next after accept", 7);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule